// File: doc/BRIEF.md
# Masked Multi-Lane Vector Execution Unit

This block carries out element-wise integer vector instructions on a small vector register file. Each register holds up to `MAX_VL` elements. Element `i` of a register is handled by lane `i mod NUM_LANES`. All lanes take the same control in a given cycle, so one group of `NUM_LANES` elements is finished per cycle. There is no traffic between lanes.

A separate vector-length register sets how many leading elements an instruction touches. Its value is captured when the instruction is issued. An instruction can also be predicated by one of the one-bit-per-element mask registers. The masks are produced by a vector not-equal compare.

Two instructions may be in flight at once. The second starts one group behind the first, so it picks up each result element of its predecessor as soon as that element has been written. It does not wait for the whole vector. A registered element read port and a mask read port give the surrounding logic access to the results.

Top module: `vx_unit`

## Requirements
- R1: After reset the vector length `vl_q` is `MAX_VL`. A write through `vl_we`/`vl_wdata` sets it to `min(vl_wdata, MAX_VL)`. Without a write it holds its value.
- R2: The opcodes on `iss_op` are decoded as follows, with element results taken modulo 2^ELEM_W (a product keeps its low ELEM_W bits):
  - 0: `vd[i] = vs1[i] + vs2[i]`
  - 1: `vd[i] = scalar + vs2[i]`
  - 2: `vd[i] = vs1[i] - vs2[i]`
  - 3: `vd[i] = scalar - vs2[i]`
  - 4: `vd[i] = vs1[i] * vs2[i]`
  - 5: `vd[i] = scalar * vs2[i]`
- R3: Opcode 7 writes the index sequence `vd[i] = scalar + i`.
- R4: Opcode 6 sets bit `i` of mask register `(vd mod NUM_MREGS)` to `(vs1[i] != vs2[i])`. It writes no vector register.
- R5: An instruction uses the VL value present in the cycle it is accepted. A later VL write does not change it. Only elements and mask bits with index below that VL are written. All others keep their values.
- R6: With `iss_masked` set, only elements whose bit in mask register `iss_mreg` is 1 are written. This applies to vector results and compare bits alike. The other elements keep their old values.
- R7: `busy` rises in the cycle after an instruction is accepted. For a lone instruction it stays high for `ceil(VL/NUM_LANES)` cycles, or 1 cycle when VL is 0. `done` is high for one cycle in the cycle in which the final writes have taken effect.
- R8: An instruction issued with VL = 0 writes no element and no mask bit.
- R9: `iss_ready` is high while fewer than two instructions are in flight. A second instruction accepted while one is running sees every result element of the first, exactly as if it had waited. An `iss_valid` presented while `iss_ready` is low is ignored.
- R10: `rd_data` shows element `rd_elem` of register `rd_vreg`, and `rd_mask` shows mask register `rd_mreg`, one clock after the address is presented.
- R11: After reset `busy` and `done` are 0, `iss_ready` is 1, and every mask register reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vl_we | input | 1 | Vector-length write strobe |
| vl_wdata | input | $clog2(MAX_VL+1) | New vector length (clamped) |
| vl_q | output | $clog2(MAX_VL+1) | Current vector length |
| iss_valid | input | 1 | Instruction present on the issue port |
| iss_ready | output | 1 | A slot is free; issue is accepted this cycle |
| iss_op | input | 3 | Opcode (see R2-R4) |
| iss_vd | input | $clog2(NUM_VREGS) | Destination register (mask index for compare) |
| iss_vs1 | input | $clog2(NUM_VREGS) | First source register |
| iss_vs2 | input | $clog2(NUM_VREGS) | Second source register |
| iss_scalar | input | ELEM_W | Broadcast scalar operand |
| iss_masked | input | 1 | Predicate writes by a mask register |
| iss_mreg | input | $clog2(NUM_MREGS) | Mask register used as predicate |
| busy | output | 1 | At least one instruction in flight |
| done | output | 1 | An instruction finished its last group |
| rd_vreg | input | $clog2(NUM_VREGS) | Read port register index |
| rd_elem | input | $clog2(MAX_VL) | Read port element index |
| rd_mreg | input | $clog2(NUM_MREGS) | Read port mask index |
| rd_data | output | ELEM_W | Registered element read data |
| rd_mask | output | MAX_VL | Registered mask read data |

## Verification
The bench builds the unit at its default sizes: 8 registers of 32 elements of 32 bits, 4 lanes and 4 mask registers. With these sizes a full-length instruction spans eight groups, long enough for a dependent instruction to start while the first is still writing. A VL of 7 leaves a partial last group, and a write of 45 exercises the clamp. Index sequences that start near 2^32 force wrap-around in add, subtract and multiply. Because there are only four mask registers, a compare destination of 6 lands on mask 2, which makes the modulo mapping observable.

// File: rtl/vx_pkg.sv
package vx_pkg;
  typedef enum logic [2:0] {
    OP_ADD_VV = 3'd0,
    OP_ADD_SV = 3'd1,
    OP_SUB_VV = 3'd2,
    OP_SUB_SV = 3'd3,
    OP_MUL_VV = 3'd4,
    OP_MUL_SV = 3'd5,
    OP_CMPNE  = 3'd6,
    OP_IOTA   = 3'd7
  } vx_op_e;
endpackage

// File: rtl/vx_lane.sv
module vx_lane
  import vx_pkg::*;
#(
  parameter int EW = 32,
  parameter int IW = 5
) (
  input  vx_op_e          op,
  input  logic [EW-1:0]   va,
  input  logic [EW-1:0]   vb,
  input  logic [EW-1:0]   scalar,
  input  logic [IW-1:0]   idx,
  output logic [EW-1:0]   res,
  output logic            ne
);
  logic [EW-1:0] a;

  always_comb begin
    // odd opcodes take the broadcast scalar as first operand
    a  = op[0] ? scalar : va;
    ne = (va != vb);
    unique case (op)
      OP_ADD_VV, OP_ADD_SV: res = a + vb;
      OP_SUB_VV, OP_SUB_SV: res = a - vb;
      OP_MUL_VV, OP_MUL_SV: res = a * vb;
      OP_IOTA:              res = scalar + EW'(idx);
      default:              res = '0;
    endcase
  end
endmodule

// File: rtl/vx_vrf.sv
module vx_vrf #(
  parameter int NREGS = 8,
  parameter int NGRP  = 8,
  parameter int LANES = 4,
  parameter int EW    = 32,
  parameter int NWP   = 2,
  parameter int NRP   = 5
) (
  input  logic                                  clk,
  input  logic [NWP-1:0][LANES-1:0]             we,
  input  logic [NWP-1:0][$clog2(NREGS)-1:0]     wreg,
  input  logic [NWP-1:0][$clog2(NGRP)-1:0]      wgrp,
  input  logic [NWP-1:0][LANES-1:0][EW-1:0]     wdata,
  input  logic [NRP-1:0][$clog2(NREGS)-1:0]     rreg,
  input  logic [NRP-1:0][$clog2(NGRP)-1:0]      rgrp,
  output logic [NRP-1:0][LANES-1:0][EW-1:0]     rdata
);
  localparam int AW = $clog2(NREGS) + $clog2(NGRP);

  // one row per (register, group); each row is split into lane slices
  logic [LANES-1:0][EW-1:0] mem [1<<AW];

  always_ff @(posedge clk) begin
    for (int p = 0; p < NWP; p++) begin
      for (int l = 0; l < LANES; l++) begin
        if (we[p][l]) mem[{wreg[p], wgrp[p]}][l] <= wdata[p][l];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NRP; p++) rdata[p] = mem[{rreg[p], rgrp[p]}];
  end
endmodule

// File: rtl/vx_unit.sv
module vx_unit
  import vx_pkg::*;
#(
  parameter int NUM_VREGS = 8,
  parameter int MAX_VL    = 32,
  parameter int ELEM_W    = 32,
  parameter int NUM_LANES = 4,
  parameter int NUM_MREGS = 4,
  localparam int VLW = $clog2(MAX_VL + 1),
  localparam int EIW = $clog2(MAX_VL),
  localparam int VRW = $clog2(NUM_VREGS),
  localparam int MRW = (NUM_MREGS > 1) ? $clog2(NUM_MREGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vl_we,
  input  logic [VLW-1:0]    vl_wdata,
  output logic [VLW-1:0]    vl_q,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [2:0]        iss_op,
  input  logic [VRW-1:0]    iss_vd,
  input  logic [VRW-1:0]    iss_vs1,
  input  logic [VRW-1:0]    iss_vs2,
  input  logic [ELEM_W-1:0] iss_scalar,
  input  logic              iss_masked,
  input  logic [MRW-1:0]    iss_mreg,
  output logic              busy,
  output logic              done,
  input  logic [VRW-1:0]    rd_vreg,
  input  logic [EIW-1:0]    rd_elem,
  input  logic [MRW-1:0]    rd_mreg,
  output logic [ELEM_W-1:0] rd_data,
  output logic [MAX_VL-1:0] rd_mask
);
  localparam int NGRP  = MAX_VL / NUM_LANES;
  localparam int GW    = $clog2(NGRP);
  localparam int LW    = $clog2(NUM_LANES);
  localparam int NSLOT = 2;
  localparam int NRP   = 2 * NSLOT + 1;
  localparam int BW    = VLW + 1;

  // ---------------- vector length register ----------------
  logic [VLW-1:0] vl_r;
  always_ff @(posedge clk) begin
    if (rst)        vl_r <= VLW'(MAX_VL);
    else if (vl_we) vl_r <= (vl_wdata > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vl_wdata;
  end
  assign vl_q = vl_r;

  AST_VL_LIMIT: assert property (@(posedge clk) disable iff (rst)
    vl_r <= VLW'(MAX_VL));                                           // R1
  AST_VL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !vl_we |=> $stable(vl_r));                                       // R1

  // ---------------- instruction slots ----------------
  logic [NSLOT-1:0]          act;
  vx_op_e                    s_op  [NSLOT];
  logic [VRW-1:0]            s_vd  [NSLOT];
  logic [VRW-1:0]            s_vs1 [NSLOT];
  logic [VRW-1:0]            s_vs2 [NSLOT];
  logic [ELEM_W-1:0]         s_sc  [NSLOT];
  logic                      s_msk [NSLOT];
  logic [MRW-1:0]            s_mr  [NSLOT];
  logic [VLW-1:0]            s_vl  [NSLOT];
  logic [GW-1:0]             s_grp [NSLOT];
  logic [NUM_MREGS-1:0][MAX_VL-1:0] mreg_q;
  logic                      done_q;

  logic [NSLOT-1:0]          take;
  logic                      accept;

  always_comb begin
    take = '0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (!act[s]) begin
        take    = '0;
        take[s] = 1'b1;
      end
    end
  end
  assign iss_ready = ~&act;
  assign accept    = iss_valid & iss_ready;

  // ---------------- lanes and register file ----------------
  logic [NSLOT-1:0]                              last;
  logic [NSLOT-1:0][NUM_LANES-1:0]               lane_en;
  logic [NSLOT-1:0][NUM_LANES-1:0]               vwe;
  logic [NSLOT-1:0][NUM_LANES-1:0]               mwe;
  logic [NSLOT-1:0][NUM_LANES-1:0]               lne;
  logic [NSLOT-1:0][NUM_LANES-1:0][ELEM_W-1:0]   lres;
  logic [NSLOT-1:0][VRW-1:0]                     wreg;
  logic [NSLOT-1:0][GW-1:0]                      wgrp;
  logic [NRP-1:0][VRW-1:0]                       rreg;
  logic [NRP-1:0][GW-1:0]                        rgrp;
  logic [NRP-1:0][NUM_LANES-1:0][ELEM_W-1:0]     rdata;

  for (genvar gs = 0; gs < NSLOT; gs++) begin : g_slot
    logic [BW-1:0] nxt_base;
    assign nxt_base     = BW'((int'(s_grp[gs]) + 1) * NUM_LANES);
    assign last[gs]     = nxt_base >= {1'b0, s_vl[gs]};
    assign rreg[2*gs]   = s_vs1[gs];
    assign rreg[2*gs+1] = s_vs2[gs];
    assign rgrp[2*gs]   = s_grp[gs];
    assign rgrp[2*gs+1] = s_grp[gs];
    assign wreg[gs]     = s_vd[gs];
    assign wgrp[gs]     = s_grp[gs];

    for (genvar gl = 0; gl < NUM_LANES; gl++) begin : g_lane
      logic [EIW-1:0] eidx;
      assign eidx = {s_grp[gs], LW'(gl)};
      assign lane_en[gs][gl] = act[gs] && (VLW'(eidx) < s_vl[gs]) &&
                               (!s_msk[gs] || mreg_q[s_mr[gs]][eidx]);
      assign vwe[gs][gl] = lane_en[gs][gl] && (s_op[gs] != OP_CMPNE);
      assign mwe[gs][gl] = lane_en[gs][gl] && (s_op[gs] == OP_CMPNE);

      vx_lane #(.EW(ELEM_W), .IW(EIW)) u_lane (
        .op     (s_op[gs]),
        .va     (rdata[2*gs][gl]),
        .vb     (rdata[2*gs+1][gl]),
        .scalar (s_sc[gs]),
        .idx    (eidx),
        .res    (lres[gs][gl]),
        .ne     (lne[gs][gl])
      );
    end
  end

  assign rreg[NRP-1] = rd_vreg;
  assign rgrp[NRP-1] = rd_elem[EIW-1:LW];

  vx_vrf #(
    .NREGS (NUM_VREGS), .NGRP (NGRP), .LANES (NUM_LANES),
    .EW    (ELEM_W),    .NWP  (NSLOT), .NRP  (NRP)
  ) u_vrf (
    .clk   (clk),
    .we    (vwe),
    .wreg  (wreg),
    .wgrp  (wgrp),
    .wdata (lres),
    .rreg  (rreg),
    .rgrp  (rgrp),
    .rdata (rdata)
  );

  // ---------------- sequencing and mask writes ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      act    <= '0;
      done_q <= 1'b0;
      mreg_q <= '0;
    end else begin
      done_q <= 1'b0;
      for (int s = 0; s < NSLOT; s++) begin
        if (act[s]) begin
          if (last[s]) begin
            act[s] <= 1'b0;
            done_q <= 1'b1;
          end else begin
            s_grp[s] <= s_grp[s] + 1'b1;
          end
          for (int l = 0; l < NUM_LANES; l++) begin
            if (mwe[s][l]) mreg_q[s_vd[s][MRW-1:0]][{s_grp[s], LW'(l)}] <= lne[s][l];
          end
        end
      end
      if (accept) begin
        for (int s = 0; s < NSLOT; s++) begin
          if (take[s]) begin
            act[s]   <= 1'b1;
            s_op[s]  <= vx_op_e'(iss_op);
            s_vd[s]  <= iss_vd;
            s_vs1[s] <= iss_vs1;
            s_vs2[s] <= iss_vs2;
            s_sc[s]  <= iss_scalar;
            s_msk[s] <= iss_masked;
            s_mr[s]  <= iss_mreg;
            s_vl[s]  <= vl_r;
            s_grp[s] <= '0;
          end
        end
      end
    end
  end

  assign busy = |act;
  assign done = done_q;

  AST_ISSUE_BUSY: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);                                                // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));                                           // R7
  AST_FULL_MEANS_BUSY: assert property (@(posedge clk) disable iff (rst)
    !iss_ready |-> busy);                                            // R9
  AST_IDLE_MASKS_STABLE: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(mreg_q));                                      // R5

  // ---------------- read port ----------------
  always_ff @(posedge clk) begin
    rd_data <= rdata[NRP-1][rd_elem[LW-1:0]];
    rd_mask <= mreg_q[rd_mreg];
  end
endmodule

// File: tb/vx_unit_tb.sv
module vx_unit_tb;
  import vx_pkg::*;

  localparam int NV = 8, MVL = 32, EW = 32, NL = 4, NM = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          vl_we = 1'b0;
  logic [5:0]    vl_wdata = '0;
  logic [5:0]    vl_q;
  logic          iss_valid = 1'b0;
  logic          iss_ready;
  logic [2:0]    iss_op = '0;
  logic [2:0]    iss_vd = '0, iss_vs1 = '0, iss_vs2 = '0;
  logic [EW-1:0] iss_scalar = '0;
  logic          iss_masked = 1'b0;
  logic [1:0]    iss_mreg = '0;
  logic          busy, done;
  logic [2:0]    rd_vreg = '0;
  logic [4:0]    rd_elem = '0;
  logic [1:0]    rd_mreg = '0;
  logic [EW-1:0] rd_data;
  logic [MVL-1:0] rd_mask;

  always #5 clk = ~clk;

  vx_unit u_dut (
    .clk(clk), .rst(rst), .vl_we(vl_we), .vl_wdata(vl_wdata), .vl_q(vl_q),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
    .iss_vd(iss_vd), .iss_vs1(iss_vs1), .iss_vs2(iss_vs2),
    .iss_scalar(iss_scalar), .iss_masked(iss_masked), .iss_mreg(iss_mreg),
    .busy(busy), .done(done), .rd_vreg(rd_vreg), .rd_elem(rd_elem),
    .rd_mreg(rd_mreg), .rd_data(rd_data), .rd_mask(rd_mask)
  );

  // reference state
  logic [EW-1:0]  mv [NV][MVL];
  logic [MVL-1:0] mm [NM];
  int             vl_m;

  int n_cmp = 0, n_err = 0;

  logic [EW-1:0] q_exp  [$];
  bit            q_kind [$];
  string         q_req  [$];
  logic          rd_issue = 1'b0, rd_pipe = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [EW-1:0] got, input logic [EW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // monitor: pops expected items as registered read data appears
  always @(posedge clk) rd_pipe <= rd_issue;
  always @(negedge clk) begin
    if (rd_pipe && q_exp.size() > 0) begin
      logic [EW-1:0] e;
      bit            k;
      string         r;
      e = q_exp.pop_front();
      k = q_kind.pop_front();
      r = q_req.pop_front();
      if (k) chk(r, "mask", rd_mask, e);
      else   chk(r, "element", rd_data, e);
    end
  end

  function automatic void model_exec(input logic [2:0] op, input int vd, input int vs1,
                                     input int vs2, input logic [EW-1:0] sc,
                                     input bit masked, input int mr);
    for (int i = 0; i < vl_m; i++) begin
      logic [EW-1:0] a, b, r;
      if (masked && !mm[mr][i]) continue;
      a = op[0] ? sc : mv[vs1][i];
      b = mv[vs2][i];
      r = '0;
      case (op)
        3'd0, 3'd1: r = a + b;
        3'd2, 3'd3: r = a - b;
        3'd4, 3'd5: r = a * b;
        3'd7:       r = sc + EW'(i);
        default:    r = '0;
      endcase
      if (op == 3'd6) mm[vd % NM][i] = (mv[vs1][i] != b);
      else            mv[vd][i] = r;
    end
  endfunction

  task automatic issue(input logic [2:0] op, input int vd, input int vs1, input int vs2,
                       input logic [EW-1:0] sc, input bit masked, input int mr);
    @(negedge clk);
    iss_op = op; iss_vd = 3'(vd); iss_vs1 = 3'(vs1); iss_vs2 = 3'(vs2);
    iss_scalar = sc; iss_masked = masked; iss_mreg = 2'(mr);
    iss_valid = 1'b1;
    chk("R9", "iss_ready at issue", 32'(iss_ready), 32'd1);
    if (iss_ready) model_exec(op, vd, vs1, vs2, sc, masked, mr);
    @(posedge clk);
    #1 iss_valid = 1'b0;
  endtask

  task automatic set_vl(input int v);
    @(negedge clk);
    vl_we = 1'b1; vl_wdata = 6'(v);
    @(posedge clk);
    #1 vl_we = 1'b0;
    vl_m = (v > MVL) ? MVL : v;
  endtask

  task automatic wait_idle();
    int c = 0;
    @(negedge clk);
    while (busy && c < 1000) begin c++; @(negedge clk); end
  endtask

  // call right after issue(): counts busy cycles, then checks done
  task automatic timed(input string req, input int exp_cycles);
    int c = 0;
    @(negedge clk);
    while (busy && c < 1000) begin c++; @(negedge clk); end
    chk(req, "busy cycles", 32'(c), 32'(exp_cycles));
    chk(req, "done pulse", 32'(done), 32'd1);
    @(negedge clk);
    chk(req, "done low after pulse", 32'(done), 32'd0);
  endtask

  task automatic read_vreg(input int r, input string req);
    for (int i = 0; i < MVL; i++) begin
      @(negedge clk);
      rd_vreg = 3'(r); rd_elem = 5'(i); rd_issue = 1'b1;
      q_exp.push_back(mv[r][i]); q_kind.push_back(1'b0); q_req.push_back(req);
    end
    @(negedge clk) rd_issue = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_mask(input int m, input string req);
    @(negedge clk);
    rd_mreg = 2'(m); rd_issue = 1'b1;
    q_exp.push_back(mm[m]); q_kind.push_back(1'b1); q_req.push_back(req);
    @(negedge clk) rd_issue = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_err++;
    $display("FAIL R7 watchdog: busy actual %0d expected 0", busy);
    summary();
    $finish;
  end

  initial begin
    for (int m = 0; m < NM; m++) mm[m] = '0;
    vl_m = MVL;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11", "busy", 32'(busy), 32'd0);
    chk("R11", "done", 32'(done), 32'd0);
    chk("R11", "iss_ready", 32'(iss_ready), 32'd1);
    chk("R1", "reset vl", 32'(vl_q), 32'd32);
    for (int m = 0; m < NM; m++) read_mask(m, "R11 R10");

    // R3 index fill of every register, first one timed (R7)
    issue(OP_IOTA, 0, 0, 0, 32'd0, 1'b0, 0);
    timed("R7", 8);
    for (int r = 1; r < NV; r++) begin
      logic [EW-1:0] base;
      base = (r == 6) ? 32'hFFFF_FFF0 : (r == 7) ? 32'h1234_5678 : EW'(r * 1000);
      issue(OP_IOTA, r, 0, 0, base, 1'b0, 0);
      wait_idle();
    end
    for (int r = 0; r < NV; r++) read_vreg(r, "R3 R10");

    // R2 arithmetic, both forms, with wrap-around
    issue(OP_ADD_VV, 1, 6, 7, 32'd0, 1'b0, 0);          wait_idle();
    issue(OP_SUB_VV, 2, 6, 7, 32'd0, 1'b0, 0);          wait_idle();
    issue(OP_MUL_VV, 3, 7, 6, 32'd0, 1'b0, 0);          wait_idle();
    issue(OP_ADD_SV, 4, 0, 6, 32'd5, 1'b0, 0);          wait_idle();
    issue(OP_SUB_SV, 5, 0, 7, 32'd3, 1'b0, 0);          wait_idle();
    issue(OP_MUL_SV, 0, 0, 7, 32'h0001_0001, 1'b0, 0);  wait_idle();
    for (int r = 0; r < 6; r++) read_vreg(r, "R2");

    // R5 partial length, R1 clamp, R8 zero length
    set_vl(7);
    chk("R1", "vl after write 7", 32'(vl_q), 32'd7);
    issue(OP_ADD_SV, 1, 0, 2, 32'd1, 1'b0, 0);
    timed("R7", 2);
    read_vreg(1, "R5");
    set_vl(45);
    chk("R1", "vl clamp", 32'(vl_q), 32'd32);
    set_vl(0);
    issue(OP_IOTA, 2, 0, 0, 32'hDEAD_0000, 1'b0, 0);
    timed("R8", 1);
    read_vreg(2, "R8");
    issue(OP_CMPNE, 0, 6, 7, 32'd0, 1'b0, 0);
    wait_idle();
    read_mask(0, "R8");

    // R4 compare, then partial overwrite keeps upper bits (R5)
    set_vl(32);
    issue(OP_IOTA, 3, 0, 0, 32'd0, 1'b0, 0);            wait_idle();
    issue(OP_MUL_VV, 4, 3, 3, 32'd0, 1'b0, 0);          wait_idle();
    issue(OP_CMPNE, 1, 3, 4, 32'd0, 1'b0, 0);           wait_idle();
    read_mask(1, "R4");
    read_vreg(4, "R2");
    set_vl(12);
    issue(OP_CMPNE, 5, 3, 3, 32'd0, 1'b0, 0);           wait_idle();
    read_mask(1, "R4 R5");

    // R6 masked writes, vector and compare
    set_vl(32);
    issue(OP_IOTA, 5, 0, 0, 32'd500, 1'b0, 0);          wait_idle();
    issue(OP_ADD_VV, 5, 3, 3, 32'd0, 1'b1, 1);          wait_idle();
    read_vreg(5, "R6");
    issue(OP_CMPNE, 6, 3, 4, 32'd0, 1'b1, 1);           wait_idle();
    read_mask(2, "R6 R4");

    // R9 chaining: dependent instruction one cycle behind
    issue(OP_MUL_SV, 6, 0, 7, 32'd3, 1'b0, 0);
    issue(OP_ADD_VV, 1, 6, 7, 32'd0, 1'b0, 0);
    @(negedge clk);
    chk("R9", "iss_ready with two in flight", 32'(iss_ready), 32'd0);
    iss_op = OP_IOTA; iss_vd = 3'd0; iss_scalar = 32'hBAD0_0000; iss_masked = 1'b0;
    iss_valid = 1'b1;
    @(posedge clk);
    #1 iss_valid = 1'b0;
    wait_idle();
    read_vreg(6, "R9");
    read_vreg(1, "R9");
    read_vreg(0, "R9 ignored issue");

    // R9 chaining through a mask register
    issue(OP_CMPNE, 3, 3, 4, 32'd0, 1'b0, 0);
    issue(OP_ADD_SV, 2, 0, 3, 32'd7, 1'b1, 3);
    wait_idle();
    read_mask(3, "R9 R4");
    read_vreg(2, "R9 R6");

    // R5 VL captured at issue, later write has no effect on it
    issue(OP_IOTA, 4, 0, 0, 32'd9000, 1'b0, 0);
    set_vl(4);
    wait_idle();
    read_vreg(4, "R5 latched vl");
    chk("R1", "vl after write 4", 32'(vl_q), 32'd4);

    repeat (3) @(negedge clk);
    chk("R10", "read queue drained", 32'(q_exp.size()), 32'd0);
    summary();
    $finish;
  end
endmodule